// File: doc/BRIEF.md
# Regulator Protection and Power-Good Supervisor

This block supervises one or more buck regulator channels from digital comparator flags. A shared chip gate tracks the supply with two hysteresis flags and a die-temperature trip with hot and cool flags. Each channel then runs its own state machine. The machine starts the channel with a forced-PWM soft-start and hands over to normal running once the soft-start node has passed both the reference and the power-good level. From then on it watches the output window.

Faults take different recovery paths. An over-voltage output turns on the low-side switch as a crowbar, and the channel returns to its previous state by itself once the flag clears. An under-voltage output in normal running latches the channel off. The latch clears only on a new rising edge of enable or on loss of chip power. An over-temperature trip removes chip power until the cool flag is seen, and every enabled channel then restarts with a full soft-start.

Top module: `reg_prot_supervisor`

## Requirements
- R1: After reset every channel is off: regulator enable, force-PWM, low-side force and soft-start restart are 0, and the power-good pull-down is 1.
- R2: Chip power is held by a register. The supply-up flag sets it, the supply-down flag clears it (clearing wins), and it holds its value while both flags are low. While chip power is up, a channel in the off state with enable high moves to soft-start on the next edge, and `ss_restart_o` is 1 for exactly the first soft-start cycle entered from off or latched.
- R3: While chip power is down, every channel is forced to the off state within one cycle, including a latched channel.
- R4: In soft-start, regulator enable and force-PWM are 1. The channel moves to run on the first edge where both `ss_ref_i` and `ss_pg_i` are 1, and force-PWM is 0 in run.
- R5: The power-good pull-down is 0 only while the channel is in run and `out_win_i` is 1. In every other case it is 1.
- R6: In soft-start, run or latched, `out_ovp_i` moves the channel to crowbar on the next edge. In crowbar, force-low-side is 1 and force-PWM is 0. When the flag clears, the channel returns to the state it left, with no latching.
- R7: `out_uvp_i` in run latches the channel on the next edge, and the latched channel has regulator enable 0. The flag has no effect during soft-start.
- R8: A latched channel stays latched while enable is held, whatever its level. A rising edge of enable (low on one edge, high on the next) restarts soft-start with a restart pulse.
- R9: `temp_hot_i` sets an over-temperature trip that removes chip power. Only `temp_cool_i` clears it. After the trip clears, an enabled channel runs a full soft-start.
- R10: Enable low in soft-start or run sends the channel to off on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_up_i | input | 1 | Supply above rising threshold |
| supply_dn_i | input | 1 | Supply below falling threshold |
| temp_hot_i | input | 1 | Die above trip temperature |
| temp_cool_i | input | 1 | Die below recovery temperature |
| en_i | input | NUM_CH | Per-channel enable |
| ss_ref_i | input | NUM_CH | Soft-start node reached reference |
| ss_pg_i | input | NUM_CH | Soft-start node reached power-good level |
| out_win_i | input | NUM_CH | Output within ±10% window |
| out_ovp_i | input | NUM_CH | Output above 120% |
| out_uvp_i | input | NUM_CH | Output below 75% |
| reg_en_o | output | NUM_CH | Regulator switching enabled |
| force_pwm_o | output | NUM_CH | Hysteretic mode inhibited |
| force_ls_o | output | NUM_CH | Low-side switch forced on |
| pg_pull_low_o | output | NUM_CH | Open-drain power-good pull-down |
| ss_restart_o | output | NUM_CH | Soft-start restart request pulse |

## Verification
The bench builds the block with the default of two channels. The channels share chip power and the temperature trip but have separate enables and output flags, so one run can show one channel latched while the other keeps running. It can also show a shared over-temperature trip or supply loss taking both channels down together. Random per-channel flags with skewed rates bring the crowbar entered from soft-start, run and latched within reach, along with an enable toggle during a latch and a supply drop in any state.

// File: rtl/sup_pkg.sv
// Shared types for the regulator supervisor.
// Assumes nothing beyond a common state encoding used by all channels.
package sup_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_SOFT = 3'd1,
        ST_RUN  = 3'd2,
        ST_CROW = 3'd3,
        ST_LOCK = 3'd4
    } sup_state_e;
endpackage

// File: rtl/sup_chip_gate.sv
// Chip-level power gate: supply hysteresis and over-temperature trip.
// Assumes the comparator flags are already synchronous to clk.
module sup_chip_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_up_i,
    input  logic supply_dn_i,
    input  logic temp_hot_i,
    input  logic temp_cool_i,
    output logic alive_o
);
    logic supply_ok_q;
    logic ot_trip_q;

    // Supply hysteresis: the falling flag wins over the rising flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           supply_ok_q <= 1'b0;
        else if (supply_dn_i) supply_ok_q <= 1'b0;
        else if (supply_up_i) supply_ok_q <= 1'b1;
    end

    // Over-temperature trip: set on hot, cleared only on cool.
    always_ff @(posedge clk) begin
        if (!rst_n)           ot_trip_q <= 1'b0;
        else if (temp_hot_i)  ot_trip_q <= 1'b1;
        else if (temp_cool_i) ot_trip_q <= 1'b0;
    end

    // Chip power is up only with a good supply and no thermal trip.
    always_comb alive_o = supply_ok_q && !ot_trip_q;

    assert_hot_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot_i |=> !alive_o);
    assert_supply_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        supply_dn_i |=> !alive_o);
endmodule

// File: rtl/sup_edge.sv
// Rising-edge detector for a level input sampled every clock.
// Assumes the input is synchronous to clk.
module sup_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Rise when the level is high now and was low on the previous edge.
    always_comb rise_o = lvl_i && !lvl_q;
endmodule

// File: rtl/sup_channel.sv
// One regulator channel: soft-start sequencing, run, over-voltage crowbar
// and under-voltage latch-off. Assumes alive_i already folds in supply and
// temperature; all flags are synchronous to clk.
module sup_channel
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alive_i,
    input  logic en_i,
    input  logic ss_ref_i,
    input  logic ss_pg_i,
    input  logic out_win_i,
    input  logic out_ovp_i,
    input  logic out_uvp_i,
    output logic reg_en_o,
    output logic force_pwm_o,
    output logic force_ls_o,
    output logic pg_pull_low_o,
    output logic ss_restart_o
);
    sup_state_e state_q, state_d;
    sup_state_e ret_q, ret_d;
    logic       restart_q, restart_d;
    logic       en_rise;

    sup_edge u_en_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (en_i),
        .rise_o (en_rise)
    );

    // Next-state selection; crowbar outranks normal drive in non-off states.
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        if (!alive_i) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF: if (en_i) state_d = ST_SOFT;
                ST_SOFT: begin
                    if (out_ovp_i) begin
                        state_d = ST_CROW;
                        ret_d   = ST_SOFT;
                    end else if (!en_i)            state_d = ST_OFF;
                    else if (ss_ref_i && ss_pg_i)  state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (out_ovp_i) begin
                        state_d = ST_CROW;
                        ret_d   = ST_RUN;
                    end else if (!en_i)   state_d = ST_OFF;
                    else if (out_uvp_i)   state_d = ST_LOCK;
                end
                ST_CROW: begin
                    if (!out_ovp_i) begin
                        if (ret_q == ST_LOCK) state_d = ST_LOCK;
                        else if (!en_i)       state_d = ST_OFF;
                        else                  state_d = ret_q;
                    end
                end
                ST_LOCK: begin
                    if (out_ovp_i) begin
                        state_d = ST_CROW;
                        ret_d   = ST_LOCK;
                    end else if (en_rise) state_d = ST_SOFT;
                end
                default: state_d = ST_OFF;
            endcase
        end
        restart_d = (state_d == ST_SOFT) &&
                    ((state_q == ST_OFF) || (state_q == ST_LOCK));
    end

    // State, return-state and restart-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            ret_q     <= ST_OFF;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ret_q     <= ret_d;
            restart_q <= restart_d;
        end
    end

    // Output decode from the current state.
    always_comb begin
        reg_en_o      = (state_q == ST_SOFT) || (state_q == ST_RUN) ||
                        ((state_q == ST_CROW) && (ret_q != ST_LOCK));
        force_pwm_o   = (state_q == ST_SOFT);
        force_ls_o    = (state_q == ST_CROW);
        pg_pull_low_o = !((state_q == ST_RUN) && out_win_i);
        ss_restart_o  = restart_q;
    end

    assert_crowbar_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_i && state_q != ST_OFF && out_ovp_i) |=> force_ls_o);
    assert_uv_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_i && state_q == ST_RUN && en_i && !out_ovp_i && out_uvp_i)
        |=> (state_q == ST_LOCK && !reg_en_o));
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_i && state_q == ST_LOCK && !out_ovp_i && !en_rise)
        |=> (state_q == ST_LOCK));
    assert_off_pg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en_o |-> pg_pull_low_o);
    assert_restart_in_soft_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart_o |-> force_pwm_o);
    assert_power_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !alive_i |=> !reg_en_o && !force_ls_o);
endmodule

// File: rtl/reg_prot_supervisor.sv
// Top: one shared chip gate and NUM_CH independent channel supervisors.
// Assumes all flags come from synchronised comparators.
module reg_prot_supervisor #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_up_i,
    input  logic              supply_dn_i,
    input  logic              temp_hot_i,
    input  logic              temp_cool_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] ss_ref_i,
    input  logic [NUM_CH-1:0] ss_pg_i,
    input  logic [NUM_CH-1:0] out_win_i,
    input  logic [NUM_CH-1:0] out_ovp_i,
    input  logic [NUM_CH-1:0] out_uvp_i,
    output logic [NUM_CH-1:0] reg_en_o,
    output logic [NUM_CH-1:0] force_pwm_o,
    output logic [NUM_CH-1:0] force_ls_o,
    output logic [NUM_CH-1:0] pg_pull_low_o,
    output logic [NUM_CH-1:0] ss_restart_o
);
    logic alive;

    sup_chip_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_up_i (supply_up_i),
        .supply_dn_i (supply_dn_i),
        .temp_hot_i  (temp_hot_i),
        .temp_cool_i (temp_cool_i),
        .alive_o     (alive)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sup_channel u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .alive_i       (alive),
            .en_i          (en_i[c]),
            .ss_ref_i      (ss_ref_i[c]),
            .ss_pg_i       (ss_pg_i[c]),
            .out_win_i     (out_win_i[c]),
            .out_ovp_i     (out_ovp_i[c]),
            .out_uvp_i     (out_uvp_i[c]),
            .reg_en_o      (reg_en_o[c]),
            .force_pwm_o   (force_pwm_o[c]),
            .force_ls_o    (force_ls_o[c]),
            .pg_pull_low_o (pg_pull_low_o[c]),
            .ss_restart_o  (ss_restart_o[c])
        );
    end

    assert_crowbar_no_pwm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls_o & force_pwm_o) == '0);
endmodule

// File: tb/sim_reg_prot_supervisor.sv
module sim_reg_prot_supervisor;
    localparam int N = 2;
    localparam int S_OFF = 0, S_SOFT = 1, S_RUN = 2, S_CROW = 3, S_LOCK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_up = 0, sup_dn = 0, hot = 0, cool = 0;
    logic [N-1:0] en = '0, ssr = '0, ssp = '0, win = '0, ovp = '0, uvp = '0;
    logic [N-1:0] reg_en, fpwm, fls, pgl, rst_req;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1 reset";

    reg_prot_supervisor #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_up_i(sup_up), .supply_dn_i(sup_dn),
        .temp_hot_i(hot), .temp_cool_i(cool), .en_i(en), .ss_ref_i(ssr),
        .ss_pg_i(ssp), .out_win_i(win), .out_ovp_i(ovp), .out_uvp_i(uvp),
        .reg_en_o(reg_en), .force_pwm_o(fpwm), .force_ls_o(fls),
        .pg_pull_low_o(pgl), .ss_restart_o(rst_req)
    );

    always #2.5 clk = ~clk;

    // Reference model state, built from the requirements.
    int m_st[N], m_ret[N];
    bit m_enq[N], m_rs[N];
    bit m_sok, m_ot;

    function automatic int next_st(int st, int ret, bit alive, bit e, bit erise,
                                   bit r, bit p, bit ov, bit uv);
        if (!alive) return S_OFF;
        case (st)
            S_OFF:  return e ? S_SOFT : S_OFF;
            S_SOFT: return ov ? S_CROW : (!e ? S_OFF : ((r && p) ? S_RUN : S_SOFT));
            S_RUN:  return ov ? S_CROW : (!e ? S_OFF : (uv ? S_LOCK : S_RUN));
            S_CROW: return ov ? S_CROW : (ret == S_LOCK ? S_LOCK : (!e ? S_OFF : ret));
            default: return ov ? S_CROW : (erise ? S_SOFT : S_LOCK);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sok <= 0; m_ot <= 0;
            for (int c = 0; c < N; c++) begin
                m_st[c] <= S_OFF; m_ret[c] <= S_OFF; m_enq[c] <= 0; m_rs[c] <= 0;
            end
        end else begin
            bit alive;
            alive = m_sok && !m_ot;
            m_sok <= sup_dn ? 1'b0 : (sup_up ? 1'b1 : m_sok);
            m_ot  <= hot ? 1'b1 : (cool ? 1'b0 : m_ot);
            for (int c = 0; c < N; c++) begin
                int ns;
                ns = next_st(m_st[c], m_ret[c], alive, en[c], en[c] && !m_enq[c],
                             ssr[c], ssp[c], ovp[c], uvp[c]);
                if (ns == S_CROW && m_st[c] != S_CROW) m_ret[c] <= m_st[c];
                m_rs[c]  <= (ns == S_SOFT) && (m_st[c] == S_OFF || m_st[c] == S_LOCK);
                m_st[c]  <= ns;
                m_enq[c] <= en[c];
            end
        end
    end

    task automatic cmp(string what, int c, bit got, bit exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d %s got %b exp %b t=%0t", tag, c, what, got, exp, $time);
        end
    endtask

    // Compare every output one ns after each rising edge.
    always @(posedge clk) begin
        #1;
        for (int c = 0; c < N; c++) begin
            cmp("reg_en", c, reg_en[c], m_st[c] == S_SOFT || m_st[c] == S_RUN ||
                (m_st[c] == S_CROW && m_ret[c] != S_LOCK));
            cmp("force_pwm", c, fpwm[c], m_st[c] == S_SOFT);
            cmp("force_ls", c, fls[c], m_st[c] == S_CROW);
            cmp("pg_pull_low", c, pgl[c], !(m_st[c] == S_RUN && win[c]));
            cmp("ss_restart", c, rst_req[c], m_rs[c]);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0A));
        step(3);
        tag = "R1 after reset";
        rst_n = 1; step(2);
        tag = "R2 start with restart pulse";
        en = '1; sup_up = 1; step(1); sup_up = 0; step(4);
        tag = "R7 uv ignored in soft-start";
        uvp = 2'b01; step(3); uvp = '0;
        tag = "R4 soft-start to run";
        ssr = '1; step(2); ssp = 2'b01; step(2); ssp = '1; step(2);
        tag = "R5 power-good window";
        win = 2'b10; step(2); win = '1; step(2);
        tag = "R6 crowbar from run";
        ovp = 2'b01; step(3); ovp = '0; step(2);
        tag = "R7 uv latch in run";
        uvp = 2'b01; step(2); uvp = '0; step(3);
        tag = "R6 crowbar from latched";
        ovp = 2'b01; step(2); ovp = '0; step(2);
        tag = "R8 latch held then enable toggle";
        step(3); en = 2'b10; step(2); en = '1; step(4);
        tag = "R10 enable low";
        en = 2'b10; step(3); en = '1; step(3);
        tag = "R9 over-temperature";
        hot = 1; step(1); hot = 0; step(4); cool = 1; step(1); cool = 0; step(6);
        tag = "R3 supply down";
        uvp = '1; step(2); uvp = '0; sup_dn = 1; step(2); sup_dn = 0; step(3);
        tag = "R2 hysteresis hold";
        step(3); sup_up = 1; step(1); sup_up = 0; step(5);
        tag = "R2 R3 R5 R6 R7 R8 R9 random";
        for (int i = 0; i < 4000; i++) begin
            sup_up = ($urandom % 8) != 0;
            sup_dn = ($urandom % 250) == 0;
            hot    = ($urandom % 400) == 0;
            cool   = ($urandom % 25) == 0;
            for (int c = 0; c < N; c++) begin
                if (($urandom % 40) == 0) en[c] = ~en[c];
                ssr[c] = ($urandom % 3) != 0;
                ssp[c] = ($urandom % 6) == 0;
                win[c] = ($urandom % 4) != 0;
                ovp[c] = ($urandom % 30) == 0;
                uvp[c] = ($urandom % 40) == 0;
            end
            step(1);
        end
        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule